// File: doc/BRIEF.md
# Barrel Shifter with Bit-Field Unit

This is a 32-bit execution unit for the immediate forms of the shift and bit-field instructions. Each issued operation brings a source operand, the current value of the destination register, a four-bit operation select and two 5-bit immediates. The immediates are a shift amount and a second value. For extract the second value is a field width, and for insert it is an end bit position. The unit returns the new destination value.

Five operations are available: logical right shift, arithmetic right shift, left shift, zero-extended field extract, and field insert. Insert merges a shifted source into the old destination and leaves the destination bits outside the field unchanged. A build-time parameter selects the latency. With one register stage the result follows one cycle after issue. With the setting that saves area, an extra stage is placed between the shift and the merge, and the result follows two cycles after issue. In both settings a new operation is accepted on every cycle.

Top module: `bfs_unit`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, valid_o is 0.
- R2: The select bits rank as follows: op_sel_i[3] (extract) over op_sel_i[2] (insert), over op_sel_i[1] (left shift), over op_sel_i[0] (arithmetic right). Any lower bits set at the same time are ignored.
- R3: When no select bit is set, the result is src_i shifted right logically by imm_shift_i, with zeros filling the vacated upper bits.
- R4: A left shift gives src_i shifted left by imm_shift_i, with zeros filling the vacated low bits.
- R5: An arithmetic right shift fills the vacated upper bits with copies of src_i[31]. A shift amount of 0 returns src_i unchanged.
- R6: An extract gives src_i shifted right by imm_shift_i. Only the low imm_width_i bits of that value are kept, and every higher bit of the result is 0.
- R7: An extract with imm_width_i equal to 0 returns 0.
- R8: An insert builds a mask that covers bits imm_shift_i through imm_width_i inclusive, counted from bit 0. The result is (src_i << imm_shift_i) on the masked bits and dst_i on all other bits. For a field of width n, imm_width_i = imm_shift_i + n - 1.
- R9: An insert with imm_width_i below imm_shift_i returns dst_i unchanged.
- R10: valid_o repeats valid_i exactly LAT cycles later, where LAT is 1 when AREA_OPT = 0 and 2 when AREA_OPT = 1. Operations issued on consecutive cycles come out on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issued this cycle |
| op_sel_i | input | 4 | Operation select: [3] extract, [2] insert, [1] left shift, [0] arithmetic right; none set gives logical right |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Current destination value, used by insert |
| imm_shift_i | input | 5 | Shift amount immediate |
| imm_width_i | input | 5 | Field width (extract) or end position (insert) |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | New destination value |

## Verification
The bench builds two instances side by side and drives them with the same stimulus: u0 with AREA_OPT = 1 and u1 with AREA_OPT = 0. Both latencies are therefore checked against one reference, including the mid-pipeline register that exists only in the two-cycle build. The stimulus opens with directed operands for sign fill, full-range shifts, zero-width extract, an empty insert mask and mixed select bits. A long run of operands follows in which valid is high on most cycles, so issue is often back to back and ordering in both pipelines is stressed.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned SEL_SRA = 0;
  localparam int unsigned SEL_SLL = 1;
  localparam int unsigned SEL_INS = 2;
  localparam int unsigned SEL_EXT = 3;

  typedef enum logic [2:0] {
    OP_SRL = 3'd0,
    OP_SRA = 3'd1,
    OP_SLL = 3'd2,
    OP_INS = 3'd3,
    OP_EXT = 3'd4
  } bfs_op_e;

  // priority: extract > insert > left > arithmetic right > logical right
  function automatic bfs_op_e bfs_decode(input logic [SEL_W-1:0] sel);
    if (sel[SEL_EXT])      return OP_EXT;
    else if (sel[SEL_INS]) return OP_INS;
    else if (sel[SEL_SLL]) return OP_SLL;
    else if (sel[SEL_SRA]) return OP_SRA;
    else                   return OP_SRL;
  endfunction
endpackage

// File: rtl/bfs_field_mask.sv
module bfs_field_mask #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [SH_W-1:0]   lo_i,
  input  logic [SH_W-1:0]   hi_i,
  output logic [DATA_W-1:0] span_mask_o,
  output logic [DATA_W-1:0] low_mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SH_W-1:0] POS = SH_W'(i);
    assign span_mask_o[i] = (lo_i <= POS) && (POS <= hi_i);
    assign low_mask_o[i]  = POS < hi_i;
  end
endmodule

// File: rtl/bfs_shift_stage.sv
module bfs_shift_stage
  import bfs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [SEL_W-1:0]  op_sel_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [SH_W-1:0]   width_i,
  output bfs_op_e           op_o,
  output logic [DATA_W-1:0] shv_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] span_mask, low_mask, srl_v, sra_v, sll_v;

  bfs_field_mask #(.DATA_W(DATA_W)) u_mask (
    .lo_i       (shamt_i),
    .hi_i       (width_i),
    .span_mask_o(span_mask),
    .low_mask_o (low_mask)
  );

  assign op_o  = bfs_decode(op_sel_i);
  assign srl_v = src_i >> shamt_i;
  assign sra_v = DATA_W'($signed(src_i) >>> shamt_i);
  assign sll_v = src_i << shamt_i;

  always_comb begin
    unique case (op_o)
      OP_SRA:         shv_o = sra_v;
      OP_SLL, OP_INS: shv_o = sll_v;
      default:        shv_o = srl_v;
    endcase
    mask_o = (op_o == OP_EXT) ? low_mask : span_mask;
  end
endmodule

// File: rtl/bfs_merge.sv
module bfs_merge
  import bfs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  bfs_op_e           op_i,
  input  logic [DATA_W-1:0] shv_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_EXT:  res_o = shv_i & mask_i;
      OP_INS:  res_o = (shv_i & mask_i) | (dst_i & ~mask_i);
      default: res_o = shv_i;
    endcase
  end
endmodule

// File: rtl/bfs_unit.sv
module bfs_unit
  import bfs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter bit          AREA_OPT = 1'b0,
  localparam int unsigned SH_W    = $clog2(DATA_W),
  localparam int unsigned LAT     = AREA_OPT ? 2 : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  op_sel_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [SH_W-1:0]   imm_shift_i,
  input  logic [SH_W-1:0]   imm_width_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  bfs_op_e           s0_op,   m_op;
  logic [DATA_W-1:0] s0_shv,  m_shv;
  logic [DATA_W-1:0] s0_mask, m_mask;
  logic [DATA_W-1:0] m_dst,   m_res;
  logic              m_valid;

  bfs_shift_stage #(.DATA_W(DATA_W)) u_shift (
    .op_sel_i(op_sel_i),
    .src_i   (src_i),
    .shamt_i (imm_shift_i),
    .width_i (imm_width_i),
    .op_o    (s0_op),
    .shv_o   (s0_shv),
    .mask_o  (s0_mask)
  );

  if (AREA_OPT) begin : g_mid
    // split between shift and merge; data regs load only on issue
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_valid <= 1'b0;
        m_op    <= OP_SRL;
        m_shv   <= '0;
        m_mask  <= '0;
        m_dst   <= '0;
      end else begin
        m_valid <= valid_i;
        if (valid_i) begin
          m_op   <= s0_op;
          m_shv  <= s0_shv;
          m_mask <= s0_mask;
          m_dst  <= dst_i;
        end
      end
    end
  end else begin : g_direct
    assign m_valid = valid_i;
    assign m_op    = s0_op;
    assign m_shv   = s0_shv;
    assign m_mask  = s0_mask;
    assign m_dst   = dst_i;
  end

  bfs_merge #(.DATA_W(DATA_W)) u_merge (
    .op_i  (m_op),
    .shv_i (m_shv),
    .mask_i(m_mask),
    .dst_i (m_dst),
    .res_o (m_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= m_valid;
      if (m_valid) result_o <= m_res;
    end
  end

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##LAT valid_o);
  assert_idle_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##LAT !valid_o);
  assert_ext_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_sel_i[SEL_EXT] && imm_width_i == '0) |-> ##LAT (result_o == '0));
  assert_ins_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_sel_i[SEL_INS] && !op_sel_i[SEL_EXT] && imm_width_i < imm_shift_i)
      |-> ##LAT (result_o == $past(dst_i, LAT)));
  assert_sra_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_sel_i == SEL_W'(1 << SEL_SRA) && imm_shift_i == '0)
      |-> ##LAT (result_o == $past(src_i, LAT)));
endmodule

// File: tb/sim_bfs_unit.sv
module sim_bfs_unit;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [3:0]  sel = '0;
  logic [31:0] src = '0, dst = '0;
  logic [4:0]  sh = '0, wd = '0;
  logic        v0, v1;
  logic [31:0] r0, r1;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { bit v; logic [31:0] r; int tag; } exp_t;
  exp_t q0[$], q1[$];

  always #4 clk = ~clk;  // 125 MHz

  bfs_unit #(.DATA_W(DW), .AREA_OPT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .op_sel_i(sel), .src_i(src),
    .dst_i(dst), .imm_shift_i(sh), .imm_width_i(wd), .valid_o(v0), .result_o(r0));
  bfs_unit #(.DATA_W(DW), .AREA_OPT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .op_sel_i(sel), .src_i(src),
    .dst_i(dst), .imm_shift_i(sh), .imm_width_i(wd), .valid_o(v1), .result_o(r1));

  function automatic logic [31:0] model(logic [3:0] s, logic [31:0] a, logic [31:0] d,
                                        int n, int w);
    logic [63:0] m64;
    logic [31:0] m;
    if (s[3]) begin
      m64 = (64'd1 << w) - 64'd1;
      return (a >> n) & m64[31:0];
    end else if (s[2]) begin
      m = '0;
      for (int i = 0; i < 32; i++) if (i >= n && i <= w) m[i] = 1'b1;
      return ((a << n) & m) | (d & ~m);
    end else if (s[1]) return a << n;
    else if (s[0]) return $unsigned($signed(a) >>> n);
    else return a >> n;
  endfunction

  // requirement tag for a result check
  function automatic int tag_of(logic [3:0] s, int n, int w);
    if (s[3]) return (w == 0) ? 7 : ((s[2:0] != 0) ? 2 : 6);
    if (s[2]) return (w < n) ? 9 : ((s[1:0] != 0) ? 2 : 8);
    if (s[1]) return s[0] ? 2 : 4;
    if (s[0]) return 5;
    return 3;
  endfunction

  task automatic chk(string who, int tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s R%0d: actual %08h expected %08h", who, tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [3:0] s, logic [31:0] a, logic [31:0] d, int n, int w);
    exp_t e, g;
    vld = v; sel = s; src = a; dst = d; sh = 5'(n); wd = 5'(w);
    e.v = v; e.r = model(s, a, d, n, w); e.tag = tag_of(s, n, w);
    q0.push_back(e); q1.push_back(e);
    @(negedge clk);
    g = q0.pop_front();
    chk("u0 valid", 10, {31'd0, v0}, {31'd0, g.v});  // R10
    if (g.v) chk("u0 result", g.tag, r0, g.r);
    g = q1.pop_front();
    chk("u1 valid", 10, {31'd0, v1}, {31'd0, g.v});  // R10
    if (g.v) chk("u1 result", g.tag, r1, g.r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog R10: actual hang expected completion");
    finish_run();
  end

  initial begin
    exp_t z;
    z.v = 0; z.r = '0; z.tag = 10;
    q0.push_back(z);  // u0 pipeline holds one extra stage
    repeat (3) @(negedge clk);
    chk("u0 reset valid", 1, {31'd0, v0}, 32'd0);  // R1
    chk("u1 reset valid", 1, {31'd0, v1}, 32'd0);  // R1
    rst_n = 1'b1;
    @(negedge clk);
    chk("u0 post-reset valid", 1, {31'd0, v0}, 32'd0);  // R1
    chk("u1 post-reset valid", 1, {31'd0, v1}, 32'd0);  // R1

    step(1, 4'b0000, 32'h8000_0001, 0, 31, 0);            // R3 -> 1
    step(1, 4'b0000, 32'hF000_000F, 0, 0, 0);             // R3 no shift
    step(1, 4'b0001, 32'h8000_0000, 0, 4, 0);             // R5 -> F8000000
    step(1, 4'b0001, 32'h9234_5678, 0, 0, 0);             // R5 pass-through
    step(1, 4'b0001, 32'h7FFF_FFFF, 0, 31, 0);            // R5 positive -> 0
    step(1, 4'b0010, 32'h0000_0001, 0, 31, 0);            // R4 -> 80000000
    step(0, 4'b0000, 32'hDEAD_BEEF, 0, 3, 0);             // R10 bubble
    step(1, 4'b1000, 32'hABCD_1234, 0, 8, 8);             // R6 -> 12
    step(1, 4'b1000, 32'hFFFF_FFFF, 0, 0, 31);            // R6 -> 7FFFFFFF
    step(1, 4'b1000, 32'hFFFF_FFFF, 0, 5, 0);             // R7 -> 0
    step(1, 4'b0100, 32'h0000_0005, 32'hFFFF_FFFF, 4, 7); // R8 -> FFFFFF5F
    step(1, 4'b0100, 32'hFFFF_FFFF, 32'h0000_0000, 0, 31);// R8 full field
    step(1, 4'b0100, 32'hFFFF_FFFF, 32'h1357_9BDF, 9, 3); // R9 -> dst
    step(1, 4'b1111, 32'hABCD_1234, 32'h5555_5555, 4, 4); // R2 extract wins
    step(1, 4'b0111, 32'h0000_00FF, 32'h0000_0000, 8, 15);// R2 insert wins
    step(1, 4'b0011, 32'h8000_0001, 0, 1, 0);             // R2 left wins
    for (int k = 0; k < 3000; k++)
      step(($urandom % 10) < 8, 4'($urandom), $urandom, $urandom,
           int'($urandom % 32), int'($urandom % 32));
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0);   // drain
    finish_run();
  end
endmodule